// File: doc/BRIEF.md
# HDLC Frame Receiver with Length and Overrun Limits

This block takes a serial HDLC bit stream, one bit per cycle of its own receive bit clock, and turns it into stored bytes. A line monitor counts runs of consecutive ones to find opening and closing flags, abort runs and idle line, and to drop the zero bits a transmitter inserts after five ones. Between flags, the data bits are packed into bytes, least significant bit first. Each byte is offered to a memory-side store port through a request/acknowledge handshake and is also folded into a 16-bit frame check sequence.

Software arms the receiver with a control write, having loaded a maximum-length value. The armed receiver hunts for a flag and takes in one frame. Reception ends at the closing flag, at an abort run, when a byte finishes while the previous byte is still waiting at the store port (overrun), or when the byte count reaches the maximum length. Each of these endings raises a sticky interrupt and records its cause in a status byte, with overrun and too-long reported active low. The flag and idle status bits follow the line at all times, armed or not. A receive reset write clears the interrupt, the count, the limit and the receive status. While the receiver is armed, writes can neither disarm it nor reset it.

Top module: `hdlc_frame_rx`

## Requirements
- R1: A 0 bit that follows exactly five consecutive 1 bits is removed from the data inside a frame; the stored bytes are the bytes before zero insertion.
- R2: A flag (a 0, six 1s, a 0) opens a frame while armed, and a later flag closes it once at least two bytes have arrived: irq rises, status bit 2 falls, and crc_ok shows whether the CRC register (reflected polynomial 0x8408, initial value 0xFFFF, bytes folded least significant bit first) holds 0xF0B8.
- R3: Seven consecutive 1 bits inside a frame end it at once with irq high, status bit 5 (abort) high, and status bit 2 low.
- R4: Status bit 3 (idle) goes high on the fifteenth consecutive 1 and low on the next 0; status bit 4 (flags) goes high when a flag ends and low on the seventh consecutive 1; both work while the receiver is disarmed.
- R5: Each finished byte raises store_req with the byte on store_data; both stay unchanged until a cycle with store_ack high, in which the byte is taken.
- R6: If a byte finishes while store_req is still high and store_ack is low, that byte is dropped and reception stops with irq high, status bit 6 low and status bit 2 low.
- R7: When the byte count after a finished byte equals the loaded maximum length, that byte is stored and reception stops with irq high, status bit 7 low and status bit 2 low.
- R8: rx_len is the 11-bit count of bytes taken into the current frame, including the two FCS bytes.
- R9: While status bit 2 (armed) is high, control writes neither clear it nor perform a receive reset.
- R10: A receive reset write while disarmed clears irq, rx_len, the maximum length and crc_ok, sets status bits 6 and 7 high, and clears status bits 2 to 5.
- R11: A flag that arrives with fewer than two bytes in the frame raises no interrupt; the receiver stays armed and that flag opens the next frame.
- R12: The status byte reads, from bit 7 down: too-long (active low), overrun (active low), abort, flags, idle, armed, then two bits that read 0; after power-on reset it reads 0xC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial receive data |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Arm request carried by a control write |
| ctl_reset | input | 1 | Receive reset request carried by a control write |
| lim_wr | input | 1 | Maximum-length load strobe |
| lim_in | input | 11 | Maximum-length value |
| store_req | output | 1 | A received byte waits to be stored |
| store_data | output | 8 | The waiting byte |
| store_ack | input | 1 | Store side takes the waiting byte |
| rx_len | output | 11 | Byte count of the current or last frame |
| status | output | 8 | Receive status byte |
| crc_ok | output | 1 | Last frame closed by a flag had a good FCS |
| irq | output | 1 | Sticky receive interrupt |

## Verification
The bench builds the block with its defaults: an 11-bit length, stuffing after five ones, abort at seven and idle at fifteen. It loads maximum lengths as small as three and four bytes, so the too-long ending is reached after a few bytes rather than near 2047. Random frames with a heavy share of 0xFF bytes force zero insertion inside data and FCS bytes. Holding store_ack low for two bytes brings the overrun ending within reach.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        RX_OFF   = 2'd0,
        RX_HUNT  = 2'd1,
        RX_FRAME = 2'd2
    } rx_state_e;

    // Events decoded from the current line bit
    typedef struct packed {
        logic flag;   // zero ending a run of exactly six ones
        logic abort;  // the one completing an abort-length run
        logic stuff;  // inserted zero after five ones
        logic data;   // bit carries frame data
    } line_ev_t;

    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_INIT      = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE   = 16'hF0B8;

endpackage

// File: rtl/hdlc_line_monitor.sv
module hdlc_line_monitor
    import hdlc_rx_pkg::*;
#(
    parameter int STUFF_RUN = 5,
    parameter int ABORT_RUN = 7,
    parameter int IDLE_RUN  = 15
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_in,
    input  logic     clr_status,
    output line_ev_t ev,
    output logic     idle_st,
    output logic     flag_st
);

    localparam int RUN_W    = $clog2(IDLE_RUN + 1);
    localparam int FLAG_RUN = ABORT_RUN - 1;

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             idle;
        logic             flag;
    } mon_t;

    mon_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        ev  = '0;
        if (bit_in) begin
            if (m_q.run != RUN_W'(IDLE_RUN)) m_d.run = m_q.run + RUN_W'(1);
            ev.abort = (m_q.run == RUN_W'(ABORT_RUN - 1));
            if (m_q.run >= RUN_W'(IDLE_RUN - 1)) m_d.idle = 1'b1;
            if (ev.abort) m_d.flag = 1'b0;
        end else begin
            m_d.run  = '0;
            m_d.idle = 1'b0;
            ev.stuff = (m_q.run == RUN_W'(STUFF_RUN));
            ev.flag  = (m_q.run == RUN_W'(FLAG_RUN));
            if (ev.flag) m_d.flag = 1'b1;
        end
        ev.data = !ev.stuff && !ev.flag;
        if (clr_status) begin
            m_d.idle = 1'b0;
            m_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign idle_st = m_q.idle;
    assign flag_st = m_q.flag;

endmodule

// File: rtl/hdlc_crc16_byte.sv
module hdlc_crc16_byte
    import hdlc_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [15:0]       crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [15:0]       crc_out
);

    logic [15:0] stage [0:BYTE_W];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        logic fb;
        assign fb           = stage[i][0] ^ byte_in[i];
        assign stage[i + 1] = (stage[i] >> 1) ^ (fb ? CRC_POLY_REFL : 16'h0000);
    end

    assign crc_out = stage[BYTE_W];

endmodule

// File: rtl/hdlc_store_port.sv
module hdlc_store_port #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              ack,
    output logic              req,
    output logic [BYTE_W-1:0] data,
    output logic              full
);

    typedef struct packed {
        logic              req;
        logic [BYTE_W-1:0] data;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (p_q.req && ack) p_d.req = 1'b0;
        if (push) begin
            p_d.req  = 1'b1;
            p_d.data = push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign req  = p_q.req;
    assign data = p_q.data;
    assign full = p_q.req && !ack;

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int BYTE_W    = 8,
    parameter int FCS_BYTES = 2,
    parameter int STUFF_RUN = 5,
    parameter int ABORT_RUN = 7,
    parameter int IDLE_RUN  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              ctl_wr,
    input  logic              ctl_enable,
    input  logic              ctl_reset,
    input  logic              lim_wr,
    input  logic [LEN_W-1:0]  lim_in,
    output logic              store_req,
    output logic [BYTE_W-1:0] store_data,
    input  logic              store_ack,
    output logic [LEN_W-1:0]  rx_len,
    output logic [7:0]        status,
    output logic              crc_ok,
    output logic              irq
);

    localparam int BIT_W = $clog2(BYTE_W);

    typedef struct packed {
        rx_state_e         st;
        logic              armed;
        logic [BYTE_W-1:0] shreg;
        logic [BIT_W-1:0]  bitcnt;
        logic [15:0]       crc;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  lim;
        logic              irq;
        logic              ab;
        logic              ovr_n;
        logic              long_n;
        logic              crc_ok;
    } regs_t;

    regs_t             r_d, r_q;
    line_ev_t          ev;
    logic              idle_st, flag_st;
    logic              rst_ok, arm_ok;
    logic              push, port_full;
    logic [BYTE_W-1:0] asm_byte;
    logic [15:0]       crc_next;
    logic [LEN_W-1:0]  cnt_inc;

    hdlc_line_monitor #(
        .STUFF_RUN (STUFF_RUN),
        .ABORT_RUN (ABORT_RUN),
        .IDLE_RUN  (IDLE_RUN)
    ) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (rx_bit),
        .clr_status (rst_ok),
        .ev         (ev),
        .idle_st    (idle_st),
        .flag_st    (flag_st)
    );

    hdlc_crc16_byte #(.BYTE_W(BYTE_W)) u_crc (
        .crc_in  (r_q.crc),
        .byte_in (asm_byte),
        .crc_out (crc_next)
    );

    hdlc_store_port #(.BYTE_W(BYTE_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (asm_byte),
        .ack       (store_ack),
        .req       (store_req),
        .data      (store_data),
        .full      (port_full)
    );

    assign asm_byte = {rx_bit, r_q.shreg[BYTE_W-1:1]};
    assign cnt_inc  = r_q.cnt + LEN_W'(1);
    assign rst_ok   = ctl_wr && ctl_reset  && !r_q.armed;
    assign arm_ok   = ctl_wr && ctl_enable && !r_q.armed;

    always_comb begin
        r_d  = r_q;
        push = 1'b0;

        if (lim_wr) r_d.lim = lim_in;

        if (rst_ok) begin
            r_d.irq    = 1'b0;
            r_d.cnt    = '0;
            r_d.lim    = '0;
            r_d.ab     = 1'b0;
            r_d.ovr_n  = 1'b1;
            r_d.long_n = 1'b1;
            r_d.crc_ok = 1'b0;
        end

        if (arm_ok) begin
            r_d.armed = 1'b1;
            r_d.st    = RX_HUNT;
        end

        if (r_q.armed) begin
            unique case (r_q.st)
                RX_HUNT: begin
                    if (ev.flag) begin
                        r_d.st     = RX_FRAME;
                        r_d.shreg  = '0;
                        r_d.bitcnt = '0;
                        r_d.crc    = CRC_INIT;
                        r_d.cnt    = '0;
                        r_d.crc_ok = 1'b0;
                    end
                end
                RX_FRAME: begin
                    if (ev.flag) begin
                        if (r_q.cnt < LEN_W'(FCS_BYTES)) begin
                            // too short: reopen on this flag
                            r_d.shreg  = '0;
                            r_d.bitcnt = '0;
                            r_d.crc    = CRC_INIT;
                            r_d.cnt    = '0;
                        end else begin
                            r_d.st     = RX_OFF;
                            r_d.armed  = 1'b0;
                            r_d.irq    = 1'b1;
                            r_d.crc_ok = (r_q.crc == CRC_RESIDUE);
                        end
                    end else if (ev.abort) begin
                        r_d.st    = RX_OFF;
                        r_d.armed = 1'b0;
                        r_d.irq   = 1'b1;
                        r_d.ab    = 1'b1;
                    end else if (ev.data) begin
                        r_d.shreg  = asm_byte;
                        r_d.bitcnt = r_q.bitcnt + BIT_W'(1);
                        if (r_q.bitcnt == BIT_W'(BYTE_W - 1)) begin
                            if (port_full) begin
                                r_d.st    = RX_OFF;
                                r_d.armed = 1'b0;
                                r_d.irq   = 1'b1;
                                r_d.ovr_n = 1'b0;
                            end else begin
                                push    = 1'b1;
                                r_d.cnt = cnt_inc;
                                r_d.crc = crc_next;
                                if (cnt_inc == r_q.lim) begin
                                    r_d.st     = RX_OFF;
                                    r_d.armed  = 1'b0;
                                    r_d.irq    = 1'b1;
                                    r_d.long_n = 1'b0;
                                end
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.crc    <= CRC_INIT;
            r_q.ovr_n  <= 1'b1;
            r_q.long_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_len = r_q.cnt;
    assign irq    = r_q.irq;
    assign crc_ok = r_q.crc_ok;
    assign status = {r_q.long_n, r_q.ovr_n, r_q.ab, flag_st, idle_st, r_q.armed, 2'b00};

endmodule

// File: rtl/hdlc_frame_rx_checker.sv
module hdlc_frame_rx_checker #(
    parameter int LEN_W  = 11,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic              ctl_reset,
    input logic              store_req,
    input logic [BYTE_W-1:0] store_data,
    input logic              store_ack,
    input logic [LEN_W-1:0]  rx_len,
    input logic [7:0]        status,
    input logic              irq
);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        store_req && !store_ack |=> store_req && $stable(store_data));

    p_overrun_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[6]) |-> irq && !status[2]);

    p_too_long_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[7]) |-> irq && !status[2]);

    p_armed_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |=> status[2] || irq);

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(ctl_wr && ctl_reset) |=> irq);

    p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_reset && !status[2] |=>
            !irq && rx_len == '0 && status[7:6] == 2'b11 && !status[5]);

    p_no_req_disarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !status[2] && !store_req |=> !store_req);

    always_comb begin
        if (rst_n) begin
            a_low_bits_r12: assert (status[1:0] == 2'b00);
        end
    end

endmodule

bind hdlc_frame_rx hdlc_frame_rx_checker #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_reset  (ctl_reset),
    .store_req  (store_req),
    .store_data (store_data),
    .store_ack  (store_ack),
    .rx_len     (rx_len),
    .status     (status),
    .irq        (irq)
);

// File: tb/hdlc_frame_rx_bench.sv
`timescale 1ns/1ps
module hdlc_frame_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit = 1'b1;
    logic        ctl_wr = 1'b0, ctl_enable = 1'b0, ctl_reset = 1'b0;
    logic        lim_wr = 1'b0;
    logic [10:0] lim_in = '0;
    logic        store_req;
    logic [7:0]  store_data;
    logic        store_ack = 1'b0;
    logic [10:0] rx_len;
    logic [7:0]  status;
    logic        crc_ok;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int ones_tx = 0;
    bit ack_on = 1'b1;
    bit finished = 1'b0;
    logic [7:0] cap [0:255];
    int cap_n = 0;
    logic [7:0] fr [0:31];
    int fr_n = 0;
    logic [7:0] exp_b [0:31];
    int exp_n = 0;

    always #10 clk = ~clk;

    hdlc_frame_rx u_hdlc_frame_rx (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
        .ctl_wr(ctl_wr), .ctl_enable(ctl_enable), .ctl_reset(ctl_reset),
        .lim_wr(lim_wr), .lim_in(lim_in),
        .store_req(store_req), .store_data(store_data), .store_ack(store_ack),
        .rx_len(rx_len), .status(status), .crc_ok(crc_ok), .irq(irq)
    );

    // store side model: takes a waiting byte one cycle after it appears
    always @(negedge clk) begin
        if (ack_on && store_req && !store_ack) begin
            if (cap_n < 256) cap[cap_n] = store_data;
            cap_n = cap_n + 1;
            store_ack = 1'b1;
        end else begin
            store_ack = 1'b0;
        end
    end

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x = c;
        for (int i = 0; i < 8; i++) begin
            if (x[0] ^ b[i]) x = (x >> 1) ^ 16'h8408;
            else             x = x >> 1;
        end
        return x;
    endfunction

    task automatic chk(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic step(input logic b);
        @(negedge clk);
        rx_bit = b;
        @(posedge clk);
        #5;
        ctl_wr = 1'b0;
        lim_wr = 1'b0;
    endtask

    task automatic tx_bit(input logic b);
        step(b);
        if (b) ones_tx++; else ones_tx = 0;
        if (ones_tx == 5) begin
            step(1'b0);
            ones_tx = 0;
        end
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_bit(v[i]);
    endtask

    task automatic tx_flag();
        step(1'b0);
        for (int i = 0; i < 6; i++) step(1'b1);
        step(1'b0);
        ones_tx = 0;
    endtask

    task automatic ctl(input logic en, input logic rs);
        ctl_wr = 1'b1; ctl_enable = en; ctl_reset = rs;
        step(1'b1);
    endtask

    task automatic set_lim(input int v);
        lim_wr = 1'b1; lim_in = 11'(v);
        step(1'b1);
    endtask

    // sends fr[0..fr_n-1], the FCS (optionally damaged) and a closing flag
    task automatic tx_body(input bit damage);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] f;
        for (int i = 0; i < fr_n; i++) begin
            c = crc_upd(c, fr[i]);
            exp_b[i] = fr[i];
            tx_byte(fr[i]);
        end
        f = ~c;
        if (damage) f = f ^ 16'h0001;
        exp_b[fr_n] = f[7:0];
        exp_b[fr_n + 1] = f[15:8];
        exp_n = fr_n + 2;
        tx_byte(f[7:0]);
        tx_byte(f[15:8]);
        tx_flag();
    endtask

    task automatic check_capture(input string tag);
        int bad = 0;
        chk({tag, " byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (cap[i] != exp_b[i]) bad++;
        chk({tag, " byte mismatches"}, bad, 0);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED1);
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        @(posedge clk); #5;

        // R12 / R10: reset state
        chk("R12 status after reset", status, 8'hC0);
        chk("R10 irq after reset", irq, 0);
        chk("R5 store_req after reset", store_req, 0);
        chk("R8 rx_len after reset", rx_len, 0);

        // R4: idle and flag status while disarmed
        step(1'b0);
        for (int i = 0; i < 14; i++) step(1'b1);
        chk("R4 idle low after 14 ones", status[3], 0);
        step(1'b1);
        chk("R4 idle high after 15 ones", status[3], 1);
        tx_flag();
        chk("R4 idle low after a zero", status[3], 0);
        chk("R4 flag seen while disarmed", status[4], 1);
        for (int i = 0; i < 6; i++) step(1'b1);
        chk("R4 flag kept after 6 ones", status[4], 1);
        step(1'b1);
        chk("R4 flag dropped at 7th one", status[4], 0);
        chk("R3 no abort while disarmed", status[5], 0);
        chk("R9 still disarmed", status[2], 0);

        // R1 / R2 / R8: directed frame full of ones
        cap_n = 0;
        ctl(1'b1, 1'b1);
        chk("R10 reset plus arm status", status, 8'hC4);
        set_lim(2000);
        tx_flag();
        fr[0] = 8'hFF; fr[1] = 8'h7E; fr[2] = 8'hFF; fr[3] = 8'h3F; fr_n = 4;
        tx_body(1'b0);
        repeat (3) step(1'b1);
        chk("R2 irq on closing flag", irq, 1);
        chk("R2 crc good", crc_ok, 1);
        chk("R2 status good frame", status, 8'hD0);
        chk("R8 length with FCS", rx_len, 6);
        check_capture("R1 unstuffed bytes");

        // R2: damaged FCS
        cap_n = 0;
        ctl(1'b1, 1'b1);
        set_lim(2000);
        tx_flag();
        fr[0] = 8'h12; fr[1] = 8'h34; fr[2] = 8'h56; fr_n = 3;
        tx_body(1'b1);
        repeat (3) step(1'b1);
        chk("R2 irq on bad frame", irq, 1);
        chk("R2 crc bad", crc_ok, 0);
        chk("R2 bad frame limits high", status[7:6], 2'b11);

        // R3: abort inside a frame
        cap_n = 0;
        ctl(1'b1, 1'b1);
        set_lim(2000);
        tx_flag();
        tx_byte(8'h00);
        tx_byte(8'h00);
        for (int i = 0; i < 6; i++) step(1'b1);
        chk("R3 no irq before 7th one", irq, 0);
        step(1'b1);
        chk("R3 irq on abort", irq, 1);
        chk("R3 abort bit", status[5], 1);
        chk("R3 disarmed", status[2], 0);
        chk("R8 length at abort", rx_len, 2);
        chk("R3 limits high", status[7:6], 2'b11);

        // R6 / R5: overrun with the store side stalled
        ack_on = 1'b0;
        cap_n = 0;
        ctl(1'b1, 1'b1);
        set_lim(2000);
        tx_flag();
        tx_byte(8'h11);
        chk("R5 request raised", store_req, 1);
        chk("R5 request data", store_data, 8'h11);
        chk("R6 no irq yet", irq, 0);
        tx_byte(8'h22);
        chk("R6 irq on overrun", irq, 1);
        chk("R6 overrun bit low", status[6], 0);
        chk("R6 too-long bit high", status[7], 1);
        chk("R6 disarmed", status[2], 0);
        chk("R6 dropped byte not counted", rx_len, 1);
        chk("R5 first byte still held", store_data, 8'h11);
        chk("R5 request still held", store_req, 1);
        ack_on = 1'b1;
        repeat (3) step(1'b1);
        chk("R5 held byte taken", cap_n, 1);
        chk("R5 request released", store_req, 0);

        // R10: receive reset after an error
        ctl(1'b0, 1'b1);
        chk("R10 irq cleared", irq, 0);
        chk("R10 length cleared", rx_len, 0);
        chk("R10 status cleared", status, 8'hC0);
        chk("R10 crc_ok cleared", crc_ok, 0);

        // R7: too-long
        cap_n = 0;
        ctl(1'b1, 1'b0);
        set_lim(4);
        tx_flag();
        for (int i = 0; i < 6; i++) fr[i] = 8'(8'hA0 + i);
        fr_n = 6;
        tx_body(1'b0);
        repeat (3) step(1'b1);
        chk("R7 irq on limit", irq, 1);
        chk("R7 too-long bit low", status[7], 0);
        chk("R7 overrun bit high", status[6], 1);
        chk("R7 length equals limit", rx_len, 4);
        chk("R7 limit byte stored", cap_n, 4);

        // R9: writes ignored while armed
        ctl(1'b0, 1'b1);
        cap_n = 0;
        ctl(1'b1, 1'b0);
        set_lim(3);
        ctl(1'b0, 1'b1);
        chk("R9 stays armed", status[2], 1);
        ctl(1'b0, 1'b0);
        chk("R9 stays armed after enable low", status[2], 1);
        tx_flag();
        for (int i = 0; i < 5; i++) fr[i] = 8'(8'h40 + i);
        fr_n = 5;
        tx_body(1'b0);
        repeat (3) step(1'b1);
        chk("R9 limit kept through ignored reset", rx_len, 3);
        chk("R9 too-long from kept limit", status[7], 0);

        // R11: short frame discarded
        ctl(1'b1, 1'b1);
        set_lim(2000);
        cap_n = 0;
        tx_flag();
        tx_byte(8'h55);
        tx_flag();
        chk("R11 no irq on short frame", irq, 0);
        chk("R11 still armed", status[2], 1);
        fr[0] = 8'h01; fr[1] = 8'h02; fr[2] = 8'h03; fr_n = 3;
        tx_body(1'b0);
        repeat (3) step(1'b1);
        chk("R11 next frame irq", irq, 1);
        chk("R11 next frame length", rx_len, 5);
        chk("R11 next frame crc", crc_ok, 1);

        // random frames, R1 R2 R5 R8
        for (int k = 0; k < 20; k++) begin
            cap_n = 0;
            ctl(1'b1, 1'b1);
            set_lim(2000);
            tx_flag();
            fr_n = 1 + int'($urandom % 12);
            for (int i = 0; i < fr_n; i++)
                fr[i] = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom);
            tx_body(1'b0);
            repeat (3) step(1'b1);
            chk("R2 random irq", irq, 1);
            chk("R2 random crc", crc_ok, 1);
            chk("R12 random status", status, 8'hD0);
            chk("R8 random length", rx_len, fr_n + 2);
            check_capture("R1 random bytes");
        end

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule